// File: doc/BRIEF.md
# Software TLB Reload Assist

This block serves a data-side translation buffer of 32 entries that software refills on every miss. It has a small register file reached through a register read/write port. The registers are a control word, the current address-space tag, a captured-page register, a first-level table base and a second-level descriptor. When a lookup misses, the block records the faulting page number in the captured-page register. While the walk assist is on, reading either table register returns a ready-made descriptor address. That address is the stored base with a table index taken from the captured page. The refill routine therefore needs no shift or mask instructions of its own.

Software then writes the real page number to a dedicated register address. That write commits an entry built from three parts: the captured page, the attributes held in the descriptor register, and the written value. The write goes to the slot named by the control index. The index then advances by itself, and a reserve option keeps the lowest four slots out of that rotation. Translation lookups are answered in the same cycle and need no handshake. The block accepts a lookup on every cycle it is offered and applies no back-pressure. Register reads are combinational, and a register write takes effect at the next clock edge.

Top module: `tlb_reload_assist`

## Requirements
- R1: After reset, the control register (address 0) reads 0x04000000: walk assist on (bit 26), reserve off (bit 27), entry index 0 (bits 12:8). No entry is valid, so every lookup misses.
- R2: The captured-page register (address 2) holds a page number in bits 31:12, an entry-valid flag in bit 9 and a 4-bit address-space tag in bits 3:0. All other bits read as zero.
- R3: A lookup that misses loads its address bits 31:12 into the captured-page register, sets bit 9 and copies the current tag. A register write to address 2 in the same cycle takes priority over this capture.
- R4: With the assist on, reading the first-level base (address 3) returns the base bits 31:12, then captured-page bits 31:22 in bits 11:2, then zeros in bits 1:0. With the assist off, it returns the base with bits 11:0 zero.
- R5: With the assist on, reading the descriptor register (address 4) returns its bits 31:12, then captured-page bits 21:12 in bits 11:2, then zeros in bits 1:0. With the assist off, it returns the stored word unchanged.
- R6: A write to address 5 commits an entry into the slot given by the control index. The entry takes its page number and tag from the captured-page register, its real page from write data bits 31:12, and its attributes from the descriptor register. The entry is valid only when captured-page bit 9 and descriptor bit 0 are both set.
- R7: After a commit, the index becomes index+1, and it wraps from 31 to 0. When reserve (bit 27) is set, an index that would fall below 4 becomes 4 instead. An index written to the control register is always used as written.
- R8: A lookup hits when some entry is valid, its tag equals the current tag, and its page number matches over the bits its size code keeps. Descriptor bits 3:2 give the size code: 00 is a 4 KB page (bits 31:12 compared), 01 is 512 KB (bits 31:19), 11 is 8 MB (bits 31:23), and 10 behaves as 4 KB. The physical address is the entry's real page above the page size and the lookup address below it.
- R9: On a hit, the block outputs the entry's access group (descriptor bits 8:5), its guarded flag (bit 4) and its write-through flag (bit 1).
- R10: When several entries hit, the one with the lowest index is used.
- R11: Address 5 and the unused addresses 6 and 7 read as zero.
- R12: The tag register (address 1) keeps write data bits 3:0, reads them back in bits 3:0 and supplies the tag that lookups compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational register read data |
| lk_valid | input | 1 | Lookup offered this cycle |
| lk_addr | input | 32 | Effective address to translate |
| lk_hit | output | 1 | Lookup hit |
| lk_paddr | output | 32 | Translated address |
| lk_guarded | output | 1 | Guarded flag of the hit entry |
| lk_wthru | output | 1 | Write-through flag of the hit entry |
| lk_group | output | 4 | Access group of the hit entry |

## Verification
Some properties are checked on every cycle:
- the hit output stays low when no lookup is offered;
- a hit passes the page offset through unchanged;
- a miss loads its page into the capture register unless a write to that register wins;
- a commit made while reserve is on never leaves the index below the floor;
- the index wraps after slot 31;
- the write-only address always reads zero.

Other behaviour is shown only by the bench's scenarios:
- the full fill, where every slot is looked up again;
- the sweep of all 32 explicit indexes, with reserve both on and off;
- the page-size masking at both edges of each size;
- the lowest-index priority;
- the computed walk addresses, with the assist on and off.

// File: rtl/tlbra_pkg.sv
package tlbra_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned PG_SHIFT = 12;
  localparam int unsigned VPN_W    = WORD_W - PG_SHIFT;
  localparam int unsigned ASID_W   = 4;
  localparam int unsigned L1_LSB   = 22;
  localparam int unsigned IDX_LSB  = 8;
  localparam int unsigned ASSIST_B = 26;
  localparam int unsigned RSV_B    = 27;

  localparam logic [2:0] RA_CTL  = 3'd0;
  localparam logic [2:0] RA_ASID = 3'd1;
  localparam logic [2:0] RA_PAGE = 3'd2;
  localparam logic [2:0] RA_L1   = 3'd3;
  localparam logic [2:0] RA_L2   = 3'd4;
  localparam logic [2:0] RA_RPN  = 3'd5;

  localparam logic [1:0] PS_4K   = 2'b00;
  localparam logic [1:0] PS_512K = 2'b01;
  localparam logic [1:0] PS_8M   = 2'b11;

  typedef struct packed {
    logic              vld;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
    logic [VPN_W-1:0]  rpn;
    logic [1:0]        size;
    logic              guarded;
    logic              wthru;
    logic [3:0]        group;
  } tlb_entry_t;

  // page-number bits that take part in the compare, per size code
  function automatic logic [VPN_W-1:0] size_mask(input logic [1:0] sz);
    logic [VPN_W-1:0] m;
    m = '1;
    case (sz)
      PS_512K: m = {{(VPN_W-7){1'b1}}, 7'b0};
      PS_8M:   m = {{(VPN_W-11){1'b1}}, 11'b0};
      default: m = '1;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/tlbra_regs.sv
module tlbra_regs
  import tlbra_pkg::*;
#(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned RSV     = 4,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic [2:0]          reg_addr,
  input  logic [WORD_W-1:0]   reg_wdata,
  output logic [WORD_W-1:0]   reg_rdata,
  input  logic                miss_cap,
  input  logic [VPN_W-1:0]    miss_vpn,
  output logic                commit,
  output logic [IDX_W-1:0]    commit_idx,
  output tlb_entry_t          new_entry,
  output logic [ASID_W-1:0]   cur_asid,
  output logic                rsv_on,
  output logic [VPN_W-1:0]    pg_vpn_o
);
  localparam logic [IDX_W:0] ENT_L = IDX_W'(ENTRIES - 1) + (IDX_W+1)'(1);
  localparam logic [IDX_W:0] RSV_L = (IDX_W+1)'(RSV);

  logic [IDX_W-1:0]  idx_q, idx_nxt;
  logic [IDX_W:0]    idx_inc;
  logic              rsv_q, assist_q;
  logic [ASID_W-1:0] asid_q;
  logic [VPN_W-1:0]  pg_vpn;
  logic              pg_vld;
  logic [ASID_W-1:0] pg_asid;
  logic [VPN_W-1:0]  l1_base;
  logic [WORD_W-1:0] l2_q;

  logic wr_ctl, wr_asid, wr_page, wr_l1, wr_l2;
  assign wr_ctl  = reg_wr && (reg_addr == RA_CTL);
  assign wr_asid = reg_wr && (reg_addr == RA_ASID);
  assign wr_page = reg_wr && (reg_addr == RA_PAGE);
  assign wr_l1   = reg_wr && (reg_addr == RA_L1);
  assign wr_l2   = reg_wr && (reg_addr == RA_L2);
  assign commit  = reg_wr && (reg_addr == RA_RPN);

  // slot after a commit: wrap at the top, then respect the reserved floor
  always_comb begin
    idx_inc = {1'b0, idx_q} + (IDX_W+1)'(1);
    if (idx_inc >= ENT_L) idx_nxt = '0;
    else                  idx_nxt = idx_inc[IDX_W-1:0];
    if (rsv_q && ({1'b0, idx_nxt} < RSV_L)) idx_nxt = RSV_L[IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q    <= '0;
      rsv_q    <= 1'b0;
      assist_q <= 1'b1;
    end else if (wr_ctl) begin
      idx_q    <= reg_wdata[IDX_LSB +: IDX_W];
      rsv_q    <= reg_wdata[RSV_B];
      assist_q <= reg_wdata[ASSIST_B];
    end else if (commit) begin
      idx_q    <= idx_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      asid_q  <= '0;
      pg_vpn  <= '0;
      pg_vld  <= 1'b0;
      pg_asid <= '0;
      l1_base <= '0;
      l2_q    <= '0;
    end else begin
      if (wr_asid) asid_q <= reg_wdata[ASID_W-1:0];
      if (wr_page) begin
        pg_vpn  <= reg_wdata[WORD_W-1:PG_SHIFT];
        pg_vld  <= reg_wdata[9];
        pg_asid <= reg_wdata[ASID_W-1:0];
      end else if (miss_cap) begin
        pg_vpn  <= miss_vpn;
        pg_vld  <= 1'b1;
        pg_asid <= asid_q;
      end
      if (wr_l1) l1_base <= reg_wdata[WORD_W-1:PG_SHIFT];
      if (wr_l2) l2_q    <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTL: begin
        reg_rdata[RSV_B]             = rsv_q;
        reg_rdata[ASSIST_B]          = assist_q;
        reg_rdata[IDX_LSB +: IDX_W]  = idx_q;
      end
      RA_ASID: reg_rdata[ASID_W-1:0] = asid_q;
      RA_PAGE: begin
        reg_rdata[WORD_W-1:PG_SHIFT] = pg_vpn;
        reg_rdata[9]                 = pg_vld;
        reg_rdata[ASID_W-1:0]        = pg_asid;
      end
      RA_L1: begin
        reg_rdata[WORD_W-1:PG_SHIFT] = l1_base;
        if (assist_q) reg_rdata[11:2] = pg_vpn[VPN_W-1 -: 10];
      end
      RA_L2: begin
        if (assist_q) reg_rdata = {l2_q[WORD_W-1:PG_SHIFT], pg_vpn[9:0], 2'b00};
        else          reg_rdata = l2_q;
      end
      default: reg_rdata = '0;
    endcase
  end

  always_comb begin
    new_entry.vld     = pg_vld & l2_q[0];
    new_entry.asid    = pg_asid;
    new_entry.vpn     = pg_vpn;
    new_entry.rpn     = reg_wdata[WORD_W-1:PG_SHIFT];
    new_entry.size    = l2_q[3:2];
    new_entry.guarded = l2_q[4];
    new_entry.wthru   = l2_q[1];
    new_entry.group   = l2_q[8:5];
  end

  assign commit_idx = idx_q;
  assign cur_asid   = asid_q;
  assign rsv_on     = rsv_q;
  assign pg_vpn_o   = pg_vpn;
endmodule

// File: rtl/tlbra_array.sv
module tlbra_array
  import tlbra_pkg::*;
#(
  parameter int unsigned ENTRIES = 32,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  tlb_entry_t                 wr_entry,
  output tlb_entry_t [ENTRIES-1:0]   ents
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    tlb_entry_t q;
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else if (wr_en && (wr_idx == IDX_W'(i))) q <= wr_entry;
    end
    assign ents[i] = q;
  end
endmodule

// File: rtl/tlbra_match.sv
module tlbra_match
  import tlbra_pkg::*;
#(
  parameter int unsigned ENTRIES = 32,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  tlb_entry_t [ENTRIES-1:0] ents,
  input  logic [WORD_W-1:0]        lk_addr,
  input  logic [ASID_W-1:0]        cur_asid,
  output logic                     any_hit,
  output logic [WORD_W-1:0]        paddr,
  output logic                     guarded,
  output logic                     wthru,
  output logic [3:0]               group
);
  logic [VPN_W-1:0]   lk_vpn;
  logic [ENTRIES-1:0] hv;
  logic [IDX_W-1:0]   sel;
  tlb_entry_t         pe;
  logic [VPN_W-1:0]   pmask;

  assign lk_vpn = lk_addr[WORD_W-1:PG_SHIFT];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic [VPN_W-1:0] m;
    assign m     = size_mask(ents[i].size);
    assign hv[i] = ents[i].vld && (ents[i].asid == cur_asid) &&
                   (((ents[i].vpn ^ lk_vpn) & m) == '0);
  end

  // lowest index wins
  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hv[i]) sel = IDX_W'(i);
    end
  end

  assign any_hit = |hv;
  assign pe      = ents[sel];
  assign pmask   = size_mask(pe.size);
  assign paddr   = {(pe.rpn & pmask) | (lk_vpn & ~pmask), lk_addr[PG_SHIFT-1:0]};
  assign guarded = pe.guarded;
  assign wthru   = pe.wthru;
  assign group   = pe.group;
endmodule

// File: rtl/tlb_reload_assist.sv
module tlb_reload_assist
  import tlbra_pkg::*;
#(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned RSV     = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        lk_valid,
  input  logic [31:0] lk_addr,
  output logic        lk_hit,
  output logic [31:0] lk_paddr,
  output logic        lk_guarded,
  output logic        lk_wthru,
  output logic [3:0]  lk_group
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);

  logic                     commit;
  logic [IDX_W-1:0]         commit_idx;
  tlb_entry_t               new_entry;
  tlb_entry_t [ENTRIES-1:0] ents;
  logic [ASID_W-1:0]        cur_asid;
  logic                     rsv_on;
  logic [VPN_W-1:0]         pg_vpn;
  logic                     any_hit;

  tlbra_regs #(.ENTRIES(ENTRIES), .RSV(RSV)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .miss_cap(lk_valid && !any_hit), .miss_vpn(lk_addr[WORD_W-1:PG_SHIFT]),
    .commit(commit), .commit_idx(commit_idx), .new_entry(new_entry),
    .cur_asid(cur_asid), .rsv_on(rsv_on), .pg_vpn_o(pg_vpn)
  );

  tlbra_array #(.ENTRIES(ENTRIES)) u_array (
    .clk(clk), .rst(rst), .wr_en(commit), .wr_idx(commit_idx),
    .wr_entry(new_entry), .ents(ents)
  );

  tlbra_match #(.ENTRIES(ENTRIES)) u_match (
    .ents(ents), .lk_addr(lk_addr), .cur_asid(cur_asid),
    .any_hit(any_hit), .paddr(lk_paddr), .guarded(lk_guarded),
    .wthru(lk_wthru), .group(lk_group)
  );

  assign lk_hit = lk_valid && any_hit;
endmodule

// File: rtl/tlbra_chk.sv
module tlbra_chk
  import tlbra_pkg::*;
#(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned RSV     = 4,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [2:0]        reg_addr,
  input logic [31:0]       reg_rdata,
  input logic              lk_valid,
  input logic [31:0]       lk_addr,
  input logic              lk_hit,
  input logic [31:0]       lk_paddr,
  input logic [IDX_W-1:0]  cur_idx,
  input logic              rsv_on,
  input logic [VPN_W-1:0]  pg_vpn
);
  logic commit_now, page_wr_now;
  assign commit_now  = reg_wr && (reg_addr == RA_RPN);
  assign page_wr_now = reg_wr && (reg_addr == RA_PAGE);

  p_idle_nohit_r8: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |-> !lk_hit);

  p_offset_pass_r8: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> (lk_paddr[11:0] == lk_addr[11:0]));

  p_miss_capture_r3: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !lk_hit && !page_wr_now) |=> (pg_vpn == $past(lk_addr[31:12])));

  p_reserve_floor_r7: assert property (@(posedge clk) disable iff (rst)
    (commit_now && rsv_on) |=> (32'(cur_idx) >= RSV));

  p_index_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (commit_now && !rsv_on && (32'(cur_idx) == ENTRIES - 1)) |=> (cur_idx == '0));

  p_rpn_reads_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == RA_RPN) |-> (reg_rdata == 32'h0));
endmodule

bind tlb_reload_assist tlbra_chk #(.ENTRIES(ENTRIES), .RSV(RSV)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .lk_valid(lk_valid), .lk_addr(lk_addr),
  .lk_hit(lk_hit), .lk_paddr(lk_paddr), .cur_idx(commit_idx),
  .rsv_on(rsv_on), .pg_vpn(pg_vpn)
);

// File: tb/sim_tlb_reload_assist.sv
module sim_tlb_reload_assist;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = 32'h0;
  logic        lk_hit;
  logic [31:0] lk_paddr;
  logic        lk_guarded, lk_wthru;
  logic [3:0]  lk_group;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic        h;
  logic [31:0] pa, rv;
  logic [5:0]  at;

  always #4 clk = ~clk;

  tlb_reload_assist u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
    .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_paddr(lk_paddr),
    .lk_guarded(lk_guarded), .lk_wthru(lk_wthru), .lk_group(lk_group)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic look(input logic [31:0] a, output logic ho, output logic [31:0] po,
                      output logic [5:0] ao);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    #1;
    ho = lk_hit; po = lk_paddr; ao = {lk_group, lk_guarded, lk_wthru};
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  function automatic logic [31:0] exp_pa(input logic [19:0] rpn, input logic [1:0] sz,
                                         input logic [31:0] a);
    logic [31:0] m;
    m = (sz == 2'b01) ? 32'hFFF8_0000 : (sz == 2'b11) ? 32'hFF80_0000 : 32'hFFFF_F000;
    return ({rpn, 12'h000} & m) | (a & ~m);
  endfunction

  function automatic int exp_idx(input int k, input bit rsv);
    int n;
    n = k + 1;
    if (n == 32) n = 0;
    if (rsv && n < 4) n = 4;
    return n;
  endfunction

  // map one 4 KB entry with asid 3 at the current index
  task automatic map4k(input logic [19:0] vpn, input logic [19:0] rpn, input logic [31:0] l2);
    wr(3'd2, {vpn, 12'h203});
    wr(3'd4, l2);
    wr(3'd5, {rpn, 12'h000});
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(3'd0, rv); check("R1 ctl reset", rv, 32'h0400_0000);
    look(32'h0000_0000, h, pa, at); check("R1 empty miss", {31'b0, h}, 32'd0);

    // R2 page register fields
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, rv); check("R2 page fields", rv, 32'hFFFF_F20F);

    // R12 tag register
    wr(3'd1, 32'hFFFF_FFF3);
    rd(3'd1, rv); check("R12 tag readback", rv, 32'h0000_0003);

    // R6 R7 R8 R9 fill every slot then look each up
    wr(3'd0, 32'h0400_0000);
    for (int i = 0; i < 32; i++) begin
      logic [31:0] l2;
      l2 = (32'(i[3:0]) << 5) | (32'(i[0]) << 4) | (32'(i[1]) << 1) | 32'h1;
      map4k(20'h10000 | 20'(i << 4), 20'h80000 + 20'(i * 3), l2);
    end
    rd(3'd0, rv); check("R7 wrap after 32 commits", rv, 32'h0400_0000);
    for (int i = 0; i < 32; i++) begin
      logic [31:0] a;
      a = {20'h10000 | 20'(i << 4), 12'h5A5};
      look(a, h, pa, at);
      check("R8 fill hit", {31'b0, h}, 32'd1);
      check("R6 fill paddr", pa, {20'h80000 + 20'(i * 3), 12'h5A5});
      check("R9 fill attrs", {26'b0, at}, {26'b0, i[3:0], i[0], i[1]});
    end
    wr(3'd1, 32'h5);
    look({20'h10000, 12'h0}, h, pa, at); check("R12 tag mismatch miss", {31'b0, h}, 32'd0);
    wr(3'd1, 32'h3);

    // R7 index sweep, reserve off and on
    for (int r = 0; r < 2; r++) begin
      for (int k = 0; k < 32; k++) begin
        wr(3'd0, (32'(r) << 27) | 32'h0400_0000 | (32'(k) << 8));
        wr(3'd2, 32'h0);
        wr(3'd5, 32'h0);
        rd(3'd0, rv);
        check("R7 next index", rv, (32'(r) << 27) | 32'h0400_0000 | (32'(exp_idx(k, r[0])) << 8));
      end
    end

    // R8 page sizes
    wr(3'd0, 32'h0400_0000);
    map4k(20'h12345, 20'hABCDE, 32'h5);
    map4k(20'h76543, 20'h13579, 32'hD);
    map4k(20'h22222, 20'h33333, 32'h9);
    look(32'h1237_FFFF & 32'hFFF8_0000 | 32'h0007_1234, h, pa, at);
    check("R8 512K hit", {31'b0, h}, 32'd1);
    check("R8 512K paddr", pa, exp_pa(20'hABCDE, 2'b01, 32'h1230_0000 | 32'h0007_1234));
    look(32'h123C_5000, h, pa, at); check("R8 512K edge miss", {31'b0, h}, 32'd0);
    look(32'h7647_FABC, h, pa, at);
    check("R8 8M hit", {31'b0, h}, 32'd1);
    check("R8 8M paddr", pa, exp_pa(20'h13579, 2'b11, 32'h7647_FABC));
    look(32'h75C0_0000, h, pa, at); check("R8 8M edge miss", {31'b0, h}, 32'd0);
    look(32'h2222_2FFF, h, pa, at);
    check("R8 code10 as 4K hit", pa, 32'h3333_3FFF);
    look(32'h2222_3000, h, pa, at); check("R8 code10 next page miss", {31'b0, h}, 32'd0);

    // R10 priority
    wr(3'd0, 32'h0400_0900);
    map4k(20'h55555, 20'h99999, 32'h1);
    wr(3'd0, 32'h0400_0500);
    map4k(20'h55555, 20'h11111, 32'h1);
    look(32'h5555_5010, h, pa, at); check("R10 lowest index wins", pa, 32'h1111_1010);
    wr(3'd0, 32'h0400_0500);
    wr(3'd2, 32'h5555_5003);
    wr(3'd5, 32'h0);
    look(32'h5555_5010, h, pa, at); check("R10 next entry after invalidate", pa, 32'h9999_9010);

    // R6 segment-valid gate
    wr(3'd0, 32'h0400_0C00);
    map4k(20'h66666, 20'h44444, 32'h0);
    look(32'h6666_6000, h, pa, at); check("R6 seg-invalid miss", {31'b0, h}, 32'd0);

    // R3 R4 R5 miss capture and walk addresses
    wr(3'd3, 32'hCAFE_0FFF);
    wr(3'd4, 32'hBEEF_01FF);
    wr(3'd0, 32'h0400_0000);
    wr(3'd1, 32'h7);
    look(32'hDEAD_B123, h, pa, at); check("R3 miss", {31'b0, h}, 32'd0);
    rd(3'd2, rv); check("R3 captured page", rv, 32'hDEAD_B207);
    rd(3'd3, rv); check("R4 level-1 walk addr", rv, 32'hCAFE_0000 | (((32'hDEAD_B123 >> 22) & 32'h3FF) << 2));
    rd(3'd4, rv); check("R5 level-2 walk addr", rv, 32'hBEEF_0000 | (((32'hDEAD_B123 >> 12) & 32'h3FF) << 2));
    wr(3'd0, 32'h0);
    rd(3'd3, rv); check("R4 assist off", rv, 32'hCAFE_0000);
    rd(3'd4, rv); check("R5 assist off", rv, 32'hBEEF_01FF);

    // R3 register write beats capture
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h1111_1203;
    lk_valid = 1'b1; lk_addr = 32'hF0F0_F000;
    @(negedge clk);
    reg_wr = 1'b0; lk_valid = 1'b0;
    rd(3'd2, rv); check("R3 write wins over capture", rv, 32'h1111_1203);

    // R11 write-only and unused addresses
    rd(3'd5, rv); check("R11 rpn reads zero", rv, 32'h0);
    rd(3'd6, rv); check("R11 addr6 zero", rv, 32'h0);
    rd(3'd7, rv); check("R11 addr7 zero", rv, 32'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule